// File: doc/BRIEF.md
# Unsigned Multiply Overflow Flag

This block reports whether the unsigned product of two W-bit operands fits in W bits. It also returns the low W bits of that product. It never builds the double-width product. It forms a product only one bit wider than the operands, and it runs a separate test on the positions of the operands' leading ones. Both results are folded into a single overflow flag.

The wide-product test covers results between 2^W and 2^(W+1)-1. The leading-one test covers every result of 2^(W+1) or more. Its fast flag is built from a running OR of the first operand, swept from its top bit downward. At each position that running OR is paired with one mirrored bit of the second operand. Any pair that is set means the two leading-zero counts add up to no more than W-2.

The result is captured in an output register by default. A parameter can make the block purely combinational. The block sits next to a datapath multiplier, or is used alone wherever only the overflow condition is needed.

Top module: `umul_ovf_detect`

## Requirements
- R1: `prod_o` equals the low W bits of the unsigned product `mul_a_i * mul_b_i`.
- R2: `ovf_o` is 1 exactly when the unsigned product is 2^W or greater, and 0 otherwise.
- R3: Whenever bit W of the product of the operands widened by one zero bit is set, `ovf_o` is 1. This is the case for products in [2^W, 2^(W+1)).
- R4: Whenever the leading-zero counts of the two operands add up to W-2 or less, `ovf_o` is 1. The fast flag that makes this test can only be set when both operands are nonzero.
- R5: If either operand is zero, then `prod_o` is 0 and `ovf_o` is 0.
- R6: If either operand equals 1, then `ovf_o` is 0 and `prod_o` equals the other operand.
- R7: While `rst_ni` is low, `prod_o` and `ovf_o` are both 0.
- R8: With the default registered output (OUT_REG=1), the outputs show the operands sampled at the previous rising edge of `clk_i`. Operands that change between edges do not alter the outputs until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the outputs |
| mul_a_i | input | W | First unsigned operand |
| mul_b_i | input | W | Second unsigned operand |
| prod_o | output | W | Low W bits of the product |
| ovf_o | output | 1 | 1 when the product does not fit in W bits |

## Verification
The combinational checks inside the submodules only look at operands that are fully known. They are skipped while an input still carries X or Z values before the bench first drives it.

The clocked properties assume the operands are steady across each rising edge. The bench meets this by changing operands only on falling edges and reading the outputs one full cycle later.

The operand pairs used include a zero operand, a unit operand, and pairs whose leading-zero sum is exactly W-2 or W-1, which lie on either side of the fast-flag threshold. A complete sweep of all operand pairs at W=8 then checks every other pair.

// File: rtl/umov_pkg.sv
package umov_pkg;

    localparam int unsigned UMOV_DEFAULT_W = 8;

    // Largest leading-zero sum that still forces an overflow.
    function automatic int lz_limit(input int unsigned width);
        return int'(width) - 2;
    endfunction

endpackage

// File: rtl/umov_prefix_or.sv
// Running OR of operand bits from the top bit down to each position i >= 1.
module umov_prefix_or #(
    parameter int unsigned W = umov_pkg::UMOV_DEFAULT_W
) (
    input  logic [W-1:1] opnd_i,
    output logic [W-1:1] seen_o
);

    logic [W-1:1] chain;

    assign chain[W-1] = opnd_i[W-1];

    for (genvar i = W - 2; i >= 1; i--) begin : g_chain
        assign chain[i] = chain[i+1] | opnd_i[i];
    end

    assign seen_o = chain;

    // A set bit at a position implies every lower position is set too.
    always_comb begin
        if (!$isunknown(opnd_i)) begin
            // R4
            prefix_mono_chk : assert (((seen_o >> 1) & ~seen_o) == '0);
        end
    end

endmodule

// File: rtl/umov_prelim.sv
// Fast flag: set when the leading-zero sum of both operands is at most W-2.
module umov_prelim #(
    parameter int unsigned W = umov_pkg::UMOV_DEFAULT_W
) (
    input  logic [W-1:1] a_hi_i,
    input  logic [W-1:1] b_hi_i,
    output logic         early_o
);

    logic [W-1:1] a_seen;
    logic [W-1:1] pair;

    umov_prefix_or #(.W(W)) u_prefix (
        .opnd_i (a_hi_i),
        .seen_o (a_seen)
    );

    // Position i pairs "a has a one at or above i" with "b has a one at W-i".
    for (genvar i = 1; i <= W - 1; i++) begin : g_pair
        assign pair[i] = a_seen[i] & b_hi_i[W-i];
    end

    assign early_o = |pair;

    always_comb begin
        if (!$isunknown({a_hi_i, b_hi_i})) begin
            // R4
            early_nonzero_chk : assert (!early_o || ((a_hi_i != '0) && (b_hi_i != '0)));
        end
    end

endmodule

// File: rtl/umov_narrow_mul.sv
// Shift-add product of the two operands widened by one zero bit, kept to W+1 bits.
module umov_narrow_mul #(
    parameter int unsigned W = umov_pkg::UMOV_DEFAULT_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W:0]   prod_o
);

    localparam int unsigned XW = W + 1;

    logic [XW-1:0] a_ext;
    logic [XW-1:0] acc [W+1];

    assign a_ext  = {1'b0, a_i};
    assign acc[0] = '0;

    for (genvar j = 0; j < W; j++) begin : g_row
        logic [XW-1:0] row;
        assign row      = b_i[j] ? (a_ext << j) : '0;
        assign acc[j+1] = acc[j] + row;
    end

    assign prod_o = acc[W];

    always_comb begin
        if (!$isunknown({a_i, b_i})) begin
            // R1
            narrow_low_chk : assert (prod_o[W-1:0] == W'(a_i * b_i));
        end
    end

endmodule

// File: rtl/umul_ovf_detect.sv
module umul_ovf_detect #(
    parameter int unsigned W       = umov_pkg::UMOV_DEFAULT_W,
    parameter bit          OUT_REG = 1'b1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] mul_a_i,
    input  logic [W-1:0] mul_b_i,
    output logic [W-1:0] prod_o,
    output logic         ovf_o
);

    localparam int LZ_LIMIT = umov_pkg::lz_limit(W);

    if (LZ_LIMIT < 0) begin : g_bad_width
        $error("umul_ovf_detect needs W of at least 2");
    end

    typedef struct packed {
        logic [W-1:0] prod;
        logic         ovf;
    } res_t;

    logic [W:0] wide_prod;
    logic       early_flag;
    res_t       res_d;
    res_t       res_q;

    umov_narrow_mul #(.W(W)) u_mul (
        .a_i    (mul_a_i),
        .b_i    (mul_b_i),
        .prod_o (wide_prod)
    );

    umov_prelim #(.W(W)) u_prelim (
        .a_hi_i  (mul_a_i[W-1:1]),
        .b_hi_i  (mul_b_i[W-1:1]),
        .early_o (early_flag)
    );

    always_comb begin
        res_d      = '0;
        res_d.prod = wide_prod[W-1:0];
        res_d.ovf  = wide_prod[W] | early_flag;
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                res_q <= '0;
            end else begin
                res_q <= res_d;
            end
        end

        // R3
        wide_top_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
            wide_prod[W] |=> ovf_o);

        // R4
        early_flag_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
            early_flag |=> ovf_o);

        // R5
        zero_operand_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
            ((mul_a_i == '0) || (mul_b_i == '0)) |=> (!ovf_o && (prod_o == '0)));

        // R6
        unit_operand_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
            ((mul_a_i == W'(1)) || (mul_b_i == W'(1))) |=> !ovf_o);
    end else begin : g_comb
        assign res_q = res_d;
    end

    assign prod_o = res_q.prod;
    assign ovf_o  = res_q.ovf;

endmodule

// File: tb/umul_ovf_detect_test.sv
module umul_ovf_detect_test;

    localparam int unsigned W        = 8;
    localparam time         CLK_PER  = 10ns;
    localparam int unsigned WATCHDOG = 150000;

    logic         clk;
    logic         rst_n;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] prod;
    logic         ovf;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    umul_ovf_detect #(.W(W), .OUT_REG(1'b1)) uut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .mul_a_i (a),
        .mul_b_i (b),
        .prod_o  (prod),
        .ovf_o   (ovf)
    );

    initial clk = 1'b0;
    always #(CLK_PER / 2) clk = ~clk;

    // {a, b, expected product, expected overflow}
    localparam int NV = 12;
    localparam logic [24:0] VEC [NV] = '{
        {8'h00, 8'hFF, 8'h00, 1'b0},   // R5 zero operand
        {8'h01, 8'hC3, 8'hC3, 1'b0},   // R6 unit operand
        {8'h80, 8'h01, 8'h80, 1'b0},   // R6
        {8'h80, 8'h02, 8'h00, 1'b1},   // R3 exactly 2^W
        {8'h10, 8'h10, 8'h00, 1'b1},   // R4 lz sum = W-2
        {8'h0F, 8'h11, 8'hFF, 1'b0},   // R2 lz sum = W-1, no overflow
        {8'h10, 8'h0F, 8'hF0, 1'b0},   // R2
        {8'h20, 8'h08, 8'h00, 1'b1},   // R3
        {8'hFF, 8'hFF, 8'h01, 1'b1},   // R4 maximum operands
        {8'h11, 8'h0F, 8'hFF, 1'b0},   // R2
        {8'h81, 8'h02, 8'h02, 1'b1},   // R3 just above 2^W
        {8'h40, 8'h40, 8'h00, 1'b1}    // R4 far above 2^(W+1)
    };

    task automatic check(input string req, input logic [W-1:0] exp_p, input logic exp_o);
        n_checks++;
        if (prod !== exp_p || ovf !== exp_o) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h got prod=%h ovf=%b, expected prod=%h ovf=%b",
                     req, a, b, prod, ovf, exp_p, exp_o);
        end
    endtask

    // Drive on a falling edge; the output register captures on the next rising edge.
    task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb);
        a = va;
        b = vb;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        a     = 8'hFF;
        b     = 8'hFF;
        repeat (3) @(negedge clk);
        check("R7", 8'h00, 1'b0);               // reset holds outputs clear
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            apply(VEC[k][24:17], VEC[k][16:9]);
            check("R1/R2", VEC[k][8:1], VEC[k][0]);
        end

        // R8: a new operand pair leaves the outputs unchanged until the next edge
        apply(8'h03, 8'h05);
        a = 8'hF0;
        b = 8'hF0;
        #1;
        check("R8", 8'h0F, 1'b0);
        @(negedge clk);
        check("R8", 8'h00, 1'b1);

        // R7: asserting reset mid-run clears the outputs
        rst_n = 1'b0;
        #1;
        check("R7", 8'h00, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: every operand pair at W=8
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                logic [2*W-1:0] full;
                full = (2*W)'(x) * (2*W)'(y);
                apply(W'(x), W'(y));
                check("R2", full[W-1:0], full >= (2*W)'(256));
            end
        end

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles without finishing, expected under %0d",
                     cyc, WATCHDOG);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule